// File: doc/BRIEF.md
# Masked Branch Sequencer for a Lockstep Processing-Element Array

This block is a control unit driving a two-dimensional grid of small processing elements (PEs), 4x4 by default. Each PE has a data register, an activity mask bit and a condition flag. Every instruction on the input port is broadcast to all PEs and executed in the same clock edge by every PE whose mask bit is clear. PEs never see each other's registers except through an explicit neighbour move. In that move every active PE copies the register of the grid neighbour in one broadcast direction. No addressing travels with the data.

Data-dependent branches work by mask manipulation, not by per-PE program counters. An "if" masks out the active PEs whose flag is clear and records the mask as it stood on entry. The following operations form the THEN arm. An "else" inverts the mask bit of only those PEs that were active on entry, and the operations after it form the ELSE arm. An "end-if" puts the recorded mask back. Only one branch level may be open at a time.

A done pulse confirms each instruction. A combinational readback port shows the register, mask and flag of any PE chosen by index.

Top module: `simd_branch_seq`

## Requirements
- R1: After reset every PE register is zero, every mask bit is clear (PE active), every flag is zero, no branch is open and done is low.
- R2: An instruction presented with instr_valid high at a rising edge takes effect at that edge, and done is high during exactly the following cycle; back-to-back instructions give back-to-back done cycles, and done is low after a cycle without instr_valid.
- R3: Opcodes 1 (load immediate), 2 (add immediate, modulo 2^DATA_W) and 3 (xor immediate) change the register only of PEs whose mask bit is 0; a PE with mask bit 1 keeps its value.
- R4: Opcode 4 makes every active PE load the register its neighbour held before the edge, the neighbour picked by instr_dir: 0 = row-1, 1 = row+1, 2 = column-1, 3 = column+1, with PE index row*GRID_W+column. A PE with no neighbour on that side loads zero.
- R5: Opcode 5 sets the flag of each active PE to (register < immediate, unsigned); flags of masked PEs are unchanged.
- R6: Opcode 8 (if) records every PE's mask bit, then sets the mask bit of each active PE whose flag is 0; PEs already masked stay masked.
- R7: Opcode 9 (else) inverts the mask bit of every PE that was active when the if executed; PEs masked at that point stay masked.
- R8: Opcode 10 (end-if) returns every mask bit to the value recorded by the if, closing the branch.
- R9: Branches nest one level deep. An if while a branch is open, an else outside a branch or after an else, and an end-if with no open branch change no PE state, yet still produce a done pulse.
- R10: Opcode 6 sets the mask bit of each active PE whose flag is 1; opcode 7 clears every mask bit. Opcode 0 and codes 11 to 15 change nothing.
- R11: A branch whose arms hold T and E single-cycle operations, issued back to back, produces T+E+3 consecutive done cycles, so the phase time is the sum of both arms plus three control steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_op | input | 4 | Opcode (see requirements) |
| instr_imm | input | DATA_W | Immediate operand broadcast to all PEs |
| instr_dir | input | 2 | Neighbour direction for the move opcode |
| done | output | 1 | High the cycle after each instruction |
| rd_idx | input | clog2(GRID_W*GRID_H) | PE selected for readback |
| rd_data | output | DATA_W | Register of the selected PE |
| rd_mask | output | 1 | Mask bit of the selected PE (1 = inactive) |
| rd_flag | output | 1 | Condition flag of the selected PE |

## Verification
The bench sets up different values per row and column through moves in all four directions. A router that wrapped at the grid edge, or took the wrong neighbour, would leave non-zero or shifted values at the border. Branches run with both fresh and pre-masked PEs. An else that inverted every mask bit would wake PEs that were masked before the branch, and an end-if that simply cleared the mask would lose that earlier masking. Stray if, else and end-if codes are issued where they must be ignored. A design without the one-level limit would overwrite the recorded mask or flip the mask a second time. A timed back-to-back branch catches any extra stall cycle added between the two arms.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;

   typedef enum logic [3:0] {
      OP_NOP    = 4'd0,
      OP_LOADI  = 4'd1,
      OP_ADDI   = 4'd2,
      OP_XORI   = 4'd3,
      OP_MOVN   = 4'd4,
      OP_CMPLT  = 4'd5,
      OP_MASKF  = 4'd6,
      OP_UNMASK = 4'd7,
      OP_IF     = 4'd8,
      OP_ELSE   = 4'd9,
      OP_ENDIF  = 4'd10
   } simd_op_e;

   typedef enum logic [1:0] {
      DIR_UP    = 2'd0,
      DIR_DOWN  = 2'd1,
      DIR_LEFT  = 2'd2,
      DIR_RIGHT = 2'd3
   } simd_dir_e;

   typedef struct packed {
      simd_op_e  op;
      simd_dir_e dir;
   } simd_cmd_t;

endpackage

// File: rtl/simd_seq_ctrl.sv
module simd_seq_ctrl
   import simd_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       instr_valid,
   input  logic [3:0] instr_op,
   input  logic [1:0] instr_dir,
   output simd_cmd_t  cmd,
   output logic       br_open,
   output logic       br_else,
   output logic       done
);

   simd_op_e raw_op;
   logic     accept;

   // Decode and filter: branch codes that break the one-level rule become NOP.
   always_comb begin
      raw_op = simd_op_e'(instr_op);
      accept = 1'b0;
      if (instr_valid) begin
         case (raw_op)
            OP_LOADI, OP_ADDI, OP_XORI, OP_MOVN,
            OP_CMPLT, OP_MASKF, OP_UNMASK: accept = 1'b1;
            OP_IF:    accept = !br_open;
            OP_ELSE:  accept = br_open && !br_else;
            OP_ENDIF: accept = br_open;
            default:  accept = 1'b0;
         endcase
      end
      cmd.op  = accept ? raw_op : OP_NOP;
      cmd.dir = simd_dir_e'(instr_dir);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br_open <= 1'b0;
         br_else <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= instr_valid;
         case (cmd.op)
            OP_IF:   br_open <= 1'b1;
            OP_ELSE: br_else <= 1'b1;
            OP_ENDIF: begin
               br_open <= 1'b0;
               br_else <= 1'b0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/simd_pe.sv
module simd_pe
   import simd_seq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  simd_op_e          op,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] nbr_in,
   output logic [DATA_W-1:0] acc_q,
   output logic              mask_q,
   output logic              flag_q,
   output logic              save_q
);

   logic live;
   assign live = !mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         mask_q <= 1'b0;
         flag_q <= 1'b0;
         save_q <= 1'b0;
      end else begin
         case (op)
            OP_LOADI:  if (live) acc_q <= imm;
            OP_ADDI:   if (live) acc_q <= acc_q + imm;
            OP_XORI:   if (live) acc_q <= acc_q ^ imm;
            OP_MOVN:   if (live) acc_q <= nbr_in;
            OP_CMPLT:  if (live) flag_q <= (acc_q < imm);
            OP_MASKF:  if (live && flag_q) mask_q <= 1'b1;
            OP_UNMASK: mask_q <= 1'b0;
            OP_IF: begin
               save_q <= mask_q;
               if (live && !flag_q) mask_q <= 1'b1;
            end
            OP_ELSE:   if (!save_q) mask_q <= !mask_q;
            OP_ENDIF:  mask_q <= save_q;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/simd_grid_route.sv
module simd_grid_route
   import simd_seq_pkg::*;
#(
   parameter int GRID_W = 4,
   parameter int GRID_H = 4,
   parameter int DATA_W = 16,
   parameter int NUM_PE = GRID_W * GRID_H
) (
   input  logic [NUM_PE-1:0][DATA_W-1:0] src,
   input  simd_dir_e                     dir,
   output logic [NUM_PE-1:0][DATA_W-1:0] dst
);

   if (NUM_PE != GRID_W * GRID_H) begin : g_bad_count
      $error("simd_grid_route: NUM_PE must equal GRID_W*GRID_H");
   end

   for (genvar r = 0; r < GRID_H; r++) begin : g_row
      for (genvar c = 0; c < GRID_W; c++) begin : g_col
         localparam int IDX = r * GRID_W + c;
         logic [DATA_W-1:0] from_up, from_down, from_left, from_right;

         if (r > 0) begin : g_up
            assign from_up = src[IDX-GRID_W];
         end else begin : g_up_edge
            assign from_up = '0;
         end

         if (r < GRID_H - 1) begin : g_down
            assign from_down = src[IDX+GRID_W];
         end else begin : g_down_edge
            assign from_down = '0;
         end

         if (c > 0) begin : g_left
            assign from_left = src[IDX-1];
         end else begin : g_left_edge
            assign from_left = '0;
         end

         if (c < GRID_W - 1) begin : g_right
            assign from_right = src[IDX+1];
         end else begin : g_right_edge
            assign from_right = '0;
         end

         assign dst[IDX] = (dir == DIR_UP)   ? from_up   :
                           (dir == DIR_DOWN) ? from_down :
                           (dir == DIR_LEFT) ? from_left : from_right;
      end
   end

endmodule

// File: rtl/simd_branch_seq.sv
module simd_branch_seq
   import simd_seq_pkg::*;
#(
   parameter  int GRID_W = 4,
   parameter  int GRID_H = 4,
   parameter  int DATA_W = 16,
   localparam int NUM_PE = GRID_W * GRID_H,
   localparam int IDX_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [3:0]        instr_op,
   input  logic [DATA_W-1:0] instr_imm,
   input  logic [1:0]        instr_dir,
   output logic              done,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_mask,
   output logic              rd_flag
);

   if (GRID_W < 1 || GRID_H < 1) begin : g_bad_grid
      $error("simd_branch_seq: grid dimensions must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("simd_branch_seq: DATA_W must be at least 1");
   end

   simd_cmd_t                     cmd;
   logic                          br_open;
   logic                          br_else;
   logic [NUM_PE-1:0][DATA_W-1:0] acc_arr;
   logic [NUM_PE-1:0][DATA_W-1:0] nbr_arr;
   logic [NUM_PE-1:0]             mask_vec;
   logic [NUM_PE-1:0]             flag_vec;
   logic [NUM_PE-1:0]             save_vec;

   simd_seq_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr_op    (instr_op),
      .instr_dir   (instr_dir),
      .cmd         (cmd),
      .br_open     (br_open),
      .br_else     (br_else),
      .done        (done)
   );

   simd_grid_route #(
      .GRID_W (GRID_W),
      .GRID_H (GRID_H),
      .DATA_W (DATA_W),
      .NUM_PE (NUM_PE)
   ) u_route (
      .src (acc_arr),
      .dir (cmd.dir),
      .dst (nbr_arr)
   );

   for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
      simd_pe #(.DATA_W(DATA_W)) u_pe (
         .clk    (clk),
         .rst_n  (rst_n),
         .op     (cmd.op),
         .imm    (instr_imm),
         .nbr_in (nbr_arr[i]),
         .acc_q  (acc_arr[i]),
         .mask_q (mask_vec[i]),
         .flag_q (flag_vec[i]),
         .save_q (save_vec[i])
      );
   end

   // Readback: full-range index needs no guard; otherwise out-of-range reads zero.
   if (NUM_PE == (1 << IDX_W)) begin : g_rd_full
      always_comb begin
         rd_data = acc_arr[rd_idx];
         rd_mask = mask_vec[rd_idx];
         rd_flag = flag_vec[rd_idx];
      end
   end else begin : g_rd_guard
      always_comb begin
         rd_data = '0;
         rd_mask = 1'b0;
         rd_flag = 1'b0;
         for (int k = 0; k < NUM_PE; k++) begin
            if (rd_idx == IDX_W'(k)) begin
               rd_data = acc_arr[k];
               rd_mask = mask_vec[k];
               rd_flag = flag_vec[k];
            end
         end
      end
   end

endmodule

// File: rtl/simd_branch_seq_chk.sv
module simd_branch_seq_chk #(
   parameter int NUM_PE = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic              done,
   input logic              br_open,
   input logic              br_else,
   input logic [NUM_PE-1:0] mask_vec,
   input logic [NUM_PE-1:0] save_vec
);

   assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |=> done);

   assert_done_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> !done);

   assert_if_keeps_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(br_open) |-> ((mask_vec & $past(mask_vec)) == $past(mask_vec)));

   assert_else_keeps_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(br_else) |-> ((mask_vec & save_vec) == save_vec));

   assert_endif_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(br_open) |-> (mask_vec == $past(save_vec)));

   assert_else_inside_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      br_else |-> br_open);

endmodule

bind simd_branch_seq simd_branch_seq_chk #(.NUM_PE(GRID_W * GRID_H)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .done        (done),
   .br_open     (br_open),
   .br_else     (br_else),
   .mask_vec    (mask_vec),
   .save_vec    (save_vec)
);

// File: tb/simd_branch_seq_bench.sv
module simd_branch_seq_bench;

   localparam int GW = 4;
   localparam int GH = 4;
   localparam int DW = 16;
   localparam int N  = GW * GH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic [3:0]    instr_op = 4'd0;
   logic [DW-1:0] instr_imm = '0;
   logic [1:0]    instr_dir = 2'd0;
   logic          done;
   logic [3:0]    rd_idx = 4'd0;
   logic [DW-1:0] rd_data;
   logic          rd_mask;
   logic          rd_flag;

   always #4 clk = ~clk;

   simd_branch_seq #(.GRID_W(GW), .GRID_H(GH), .DATA_W(DW)) u_simd_branch_seq (
      .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr_op (instr_op),
      .instr_imm (instr_imm), .instr_dir (instr_dir), .done (done), .rd_idx (rd_idx),
      .rd_data (rd_data), .rd_mask (rd_mask), .rd_flag (rd_flag)
   );

   // Reference model state, written from the requirements.
   logic [DW-1:0] m_acc [N];
   logic [DW-1:0] m_old [N];
   bit            m_mask [N];
   bit            m_flag [N];
   bit            m_save [N];
   bit            m_open;
   bit            m_else;

   typedef struct {
      int            idx;
      logic [DW-1:0] data;
      bit            mask;
      bit            flag;
      string         tag;
   } exp_t;

   exp_t sbq[$];
   int   vectors = 0;
   int   miscompares = 0;
   bit   finished = 0;
   int   run_cur = 0;
   int   run_last = 0;

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   task automatic check_val(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] neighbour(int i, logic [1:0] d);
      int r = i / GW;
      int c = i % GW;
      case (d)
         2'd0: return (r > 0)      ? m_old[i-GW] : '0;
         2'd1: return (r < GH - 1) ? m_old[i+GW] : '0;
         2'd2: return (c > 0)      ? m_old[i-1]  : '0;
         default: return (c < GW - 1) ? m_old[i+1] : '0;
      endcase
   endfunction

   task automatic model_apply(logic [3:0] op, logic [DW-1:0] imm, logic [1:0] d);
      for (int i = 0; i < N; i++) m_old[i] = m_acc[i];
      case (op)
         4'd8: if (!m_open) begin
            m_open = 1;
            for (int i = 0; i < N; i++) begin
               m_save[i] = m_mask[i];
               if (!m_mask[i] && !m_flag[i]) m_mask[i] = 1;
            end
         end
         4'd9: if (m_open && !m_else) begin
            m_else = 1;
            for (int i = 0; i < N; i++) if (!m_save[i]) m_mask[i] = !m_mask[i];
         end
         4'd10: if (m_open) begin
            m_open = 0;
            m_else = 0;
            for (int i = 0; i < N; i++) m_mask[i] = m_save[i];
         end
         4'd7: for (int i = 0; i < N; i++) m_mask[i] = 0;
         default: for (int i = 0; i < N; i++) begin
            if (!m_mask[i]) begin
               case (op)
                  4'd1: m_acc[i] = imm;
                  4'd2: m_acc[i] = m_old[i] + imm;
                  4'd3: m_acc[i] = m_old[i] ^ imm;
                  4'd4: m_acc[i] = neighbour(i, d);
                  4'd5: m_flag[i] = (m_old[i] < imm);
                  4'd6: if (m_flag[i]) m_mask[i] = 1;
                  default: ;
               endcase
            end
         end
      endcase
   endtask

   // Driver: present one instruction at a falling edge and keep it for one cycle.
   task automatic send(logic [3:0] op, logic [DW-1:0] imm, logic [1:0] d);
      @(negedge clk);
      instr_valid = 1'b1;
      instr_op    = op;
      instr_imm   = imm;
      instr_dir   = d;
      model_apply(op, imm, d);
   endtask

   task automatic run1(logic [3:0] op, logic [DW-1:0] imm, logic [1:0] d);
      send(op, imm, d);
      @(negedge clk);
      instr_valid = 1'b0;
      check_val("R2 done after instruction", int'(done), 1);
   endtask

   task automatic check_all(string tag);
      exp_t e;
      for (int i = 0; i < N; i++) begin
         e.idx  = i;
         e.data = m_acc[i];
         e.mask = m_mask[i];
         e.flag = m_flag[i];
         e.tag  = tag;
         sbq.push_back(e);
      end
      wait (sbq.size() == 0);
      @(negedge clk);
   endtask

   // Monitor: pops expected PE states and compares them through the readback port.
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (sbq.size() > 0) begin
            e = sbq.pop_front();
            rd_idx = e.idx[3:0];
            #1;
            vectors++;
            if (rd_data !== e.data || rd_mask !== e.mask || rd_flag !== e.flag) begin
               miscompares++;
               $display("FAIL %s pe %0d: actual data %0d mask %b flag %b, expected data %0d mask %b flag %b",
                        e.tag, e.idx, rd_data, rd_mask, rd_flag, e.data, e.mask, e.flag);
            end
         end
      end
   end

   // Length of the most recent run of consecutive done cycles.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) run_cur++;
         else if (run_cur > 0) begin
            run_last = run_cur;
            run_cur  = 0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_acc[i] = '0; m_mask[i] = 0; m_flag[i] = 0; m_save[i] = 0;
      end
      m_open = 0;
      m_else = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_val("R1 done low after reset", int'(done), 0);
      check_all("R1 reset state");

      // R3 / R4: build row- and column-dependent values with moves in every direction.
      run1(4'd1, 16'd3, 2'd0);
      for (int k = 0; k < 3; k++) begin
         run1(4'd4, '0, 2'd2);
         run1(4'd2, 16'd7, 2'd0);
      end
      @(negedge clk);
      check_val("R2 done low when idle", int'(done), 0);
      check_all("R4 move from left");
      run1(4'd4, '0, 2'd0);
      check_all("R4 move from above, top row zero");
      run1(4'd2, 16'd1, 2'd0);
      run1(4'd4, '0, 2'd1);
      check_all("R4 move from below, bottom row zero");
      run1(4'd4, '0, 2'd3);
      check_all("R4 move from right, right column zero");
      run1(4'd3, 16'h0001, 2'd0);
      run1(4'd3, 16'h0001, 2'd0);
      check_all("R3 xor twice restores");

      // R5..R8: a plain branch with all PEs active on entry.
      run1(4'd5, 16'd20, 2'd0);
      check_all("R5 compare flags");
      run1(4'd8, '0, 2'd0);
      check_all("R6 if masks false PEs");
      run1(4'd2, 16'd100, 2'd0);
      check_all("R3 then arm touches active only");
      run1(4'd9, '0, 2'd0);
      check_all("R7 else flips mask");
      run1(4'd2, 16'd200, 2'd0);
      check_all("R3 else arm touches active only");
      run1(4'd10, '0, 2'd0);
      check_all("R8 end-if restores mask");

      // R10 / R5 / R6..R8 with PEs masked before the branch.
      run1(4'd5, 16'd200, 2'd0);
      run1(4'd6, '0, 2'd0);
      check_all("R10 mask on flag");
      run1(4'd5, 16'd300, 2'd0);
      check_all("R5 masked flags held");
      run1(4'd4, '0, 2'd0);
      run1(4'd5, 16'd150, 2'd0);
      run1(4'd8, '0, 2'd0);
      check_all("R6 premasked stay masked");
      run1(4'd2, 16'd1, 2'd0);
      run1(4'd9, '0, 2'd0);
      check_all("R7 premasked stay masked on else");
      run1(4'd2, 16'd2, 2'd0);
      run1(4'd10, '0, 2'd0);
      check_all("R8 premasked mask restored");

      // R9: stray branch codes are ignored but still acknowledged.
      run1(4'd10, '0, 2'd0);
      run1(4'd9, '0, 2'd0);
      check_all("R9 end-if and else outside branch ignored");
      run1(4'd8, '0, 2'd0);
      run1(4'd8, '0, 2'd0);
      check_all("R9 nested if ignored");
      run1(4'd9, '0, 2'd0);
      run1(4'd9, '0, 2'd0);
      check_all("R9 second else ignored");
      run1(4'd10, '0, 2'd0);
      check_all("R9 branch closed");
      run1(4'd12, 16'hFFFF, 2'd0);
      run1(4'd0, 16'hFFFF, 2'd0);
      check_all("R10 undefined and no-op codes");
      run1(4'd7, '0, 2'd0);
      check_all("R10 unmask all");

      // R11: one add per arm, issued back to back.
      run1(4'd5, 16'd100, 2'd0);
      @(negedge clk);
      send(4'd8, '0, 2'd0);
      send(4'd2, 16'd10, 2'd0);
      send(4'd9, '0, 2'd0);
      send(4'd2, 16'd20, 2'd0);
      send(4'd10, '0, 2'd0);
      @(negedge clk);
      instr_valid = 1'b0;
      repeat (2) @(negedge clk);
      check_val("R11 branch phase cycles", run_last, 1 + 1 + 3);
      check_all("R11 branch result");

      finish_run();
   end

endmodule